// File: doc/BRIEF.md
# Serial Two-Wire Memory Slave Protocol Controller

This block is the protocol engine of a two-wire (I2C) slave memory holding 8K bytes. A separate bus condition detector feeds it one-cycle strobes for START, STOP, SCL rising and SCL falling, along with the sampled SDA level. The engine decodes the slave select byte and a two-byte address. It then hands received bytes, with their addresses, to a page buffer, or it fetches bytes from a synchronous memory port and shifts them out. Its only output onto the wire is an enable that pulls SDA low. That enable is used for acknowledge bits and for zero data bits.

A single internal address counter serves all accesses. A write operation loads the counter from the address bytes. Each byte that is written or fetched advances it, and it wraps across the whole array. As a result, a host can do three kinds of read. It can read at the current counter. It can first load the counter with a write that carries no data and then issue a repeated START. Or it can keep acknowledging bytes to stream through memory. While the external write cycle is running, the engine stays silent so that the host can poll the device for completion.

Top module: `smem_proto_ctrl`

## Requirements
- R1: After reset the SDA pull-down enable, the write push strobe and the memory fetch strobe are all low.
- R2: The select byte is received MSB first. When its upper seven bits equal 1010100, the engine drives ACK (pull low) during the 9th clock. Bit 0 selects the direction, with 1 meaning read. A select byte with any other upper bits gets no ACK, and every later byte goes unacknowledged until the next START.
- R3: A write select (0xA8) is followed by an address high byte, an address low byte and then data bytes. Each of these is acknowledged. Each data byte is pushed out with the counter value as its address, and the counter then advances by one.
- R4: Of the 16 address bits, only the low 13 are used. Bits 15 to 13 have no effect on the address selected.
- R5: A read select (0xA9) without a preceding address phase returns the byte at the internal counter, and the counter then advances by one.
- R6: A random read loads the counter with a write select and two address bytes. A repeated START and a read select (0xA9) then return the byte at that address.
- R7: If the host acknowledges a read byte (SDA low in the 9th clock), the next byte is output from the following address. The address after 0x1FFF is 0x0000.
- R8: If the host does not acknowledge a read byte (SDA high in the 9th clock), the transfer ends. The engine drives nothing on the clocks that follow, and the host reads 0xFF.
- R9: While the busy input is high, a matching select byte is not acknowledged.
- R10: A START or STOP in any state aborts the current transfer and releases SDA. After a STOP, later bytes get no ACK.
- R11: The pull-down enable changes only after an SCL fall, START or STOP. A 1 data bit leaves the line released, and the engine releases SDA during the host's acknowledge clock of a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| startEv | input | 1 | One-cycle strobe: START or repeated START seen |
| stopEv | input | 1 | One-cycle strobe: STOP seen |
| sclRise | input | 1 | One-cycle strobe: SCL rising edge |
| sclFall | input | 1 | One-cycle strobe: SCL falling edge |
| sdaIn | input | 1 | Sampled SDA level |
| busy | input | 1 | External write cycle in progress |
| sdaPullLow | output | 1 | Drive SDA low when 1 (open drain) |
| wrValid | output | 1 | One-cycle push of a received data byte |
| wrAddr | output | 13 | Address of the pushed byte |
| wrData | output | 8 | Pushed data byte |
| rdEn | output | 1 | Memory fetch request |
| rdAddr | output | 13 | Memory fetch address |
| rdData | input | 8 | Fetched byte, valid one cycle after rdEn |

## Verification
Random reads are driven from a table of addresses. These include the lowest address, the top address and one with the ignored upper address bits set, so that address assembly and masking are told apart from plain counter behaviour. Directed sequences then cover the rest. A page write followed by two current reads shows whether the counter advances per byte. An acknowledged stream across 0x1FFF separates whole-array wraparound from page-local wrap. A wrong select code, a busy poll, a mid-address START and a STOP each show whether the engine stays silent at exactly the point the protocol requires.

// File: rtl/smem_pkg.sv
package smem_pkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_SEL,
    PH_AHI,
    PH_ALO,
    PH_WDAT,
    PH_RDAT
  } phase_t;

  // strobes from control to datapath, one cycle each
  typedef struct packed {
    logic shiftIn;
    logic loadHi;
    logic loadLo;
    logic pushWr;
    logic fetchRd;
  } strobe_t;

endpackage

// File: rtl/smem_ctrl.sv
module smem_ctrl
  import smem_pkg::*;
#(
  parameter logic [6:0] SEL_CODE = 7'b1010100
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          startEv,
  input  logic          stopEv,
  input  logic          sclRise,
  input  logic          sclFall,
  input  logic          sdaIn,
  input  logic          busy,
  input  logic [7:0]    rxByte,
  input  logic [7:0]    txByte,
  output strobe_t       strb,
  output logic          sdaPullLow
);

  phase_t     phase, nextPhase;
  logic [3:0] bitCnt;
  logic       ackOn;
  logic       receiving, byteDone, selHit, hostAckSlot;

  assign receiving   = (phase == PH_SEL) || (phase == PH_AHI) ||
                       (phase == PH_ALO) || (phase == PH_WDAT);
  assign byteDone    = sclRise && receiving && (bitCnt == 4'd7);
  assign selHit      = (rxByte[7:1] == SEL_CODE) && !busy;
  assign hostAckSlot = sclRise && (phase == PH_RDAT) && (bitCnt == 4'd8);

  always_comb begin
    strb = '0;
    if (!startEv && !stopEv) begin
      strb.shiftIn = sclRise && receiving && (bitCnt < 4'd8);
      if (byteDone) begin
        case (phase)
          PH_SEL:  strb.fetchRd = selHit && rxByte[0];
          PH_AHI:  strb.loadHi  = 1'b1;
          PH_ALO:  strb.loadLo  = 1'b1;
          PH_WDAT: strb.pushWr  = 1'b1;
          default: ;
        endcase
      end
      if (hostAckSlot && !sdaIn) strb.fetchRd = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phase      <= PH_IDLE;
      nextPhase  <= PH_IDLE;
      bitCnt     <= '0;
      ackOn      <= 1'b0;
      sdaPullLow <= 1'b0;
    end else if (startEv) begin
      phase      <= PH_SEL;
      bitCnt     <= '0;
      ackOn      <= 1'b0;
      sdaPullLow <= 1'b0;
    end else if (stopEv) begin
      phase      <= PH_IDLE;
      bitCnt     <= '0;
      ackOn      <= 1'b0;
      sdaPullLow <= 1'b0;
    end else if (phase != PH_IDLE) begin
      if (sclRise) begin
        if (bitCnt < 4'd9) bitCnt <= bitCnt + 4'd1;
        if (byteDone) begin
          case (phase)
            PH_SEL: begin
              ackOn     <= selHit;
              nextPhase <= !selHit ? PH_IDLE : (rxByte[0] ? PH_RDAT : PH_AHI);
            end
            PH_AHI: begin ackOn <= 1'b1; nextPhase <= PH_ALO;  end
            PH_ALO: begin ackOn <= 1'b1; nextPhase <= PH_WDAT; end
            default: begin ackOn <= 1'b1; nextPhase <= PH_WDAT; end
          endcase
        end
        if (hostAckSlot) begin
          ackOn     <= 1'b0;
          nextPhase <= sdaIn ? PH_IDLE : PH_RDAT;
        end
      end else if (sclFall) begin
        if (bitCnt == 4'd8) begin
          sdaPullLow <= ackOn;
        end else if (bitCnt == 4'd9) begin
          bitCnt     <= '0;
          ackOn      <= 1'b0;
          phase      <= nextPhase;
          sdaPullLow <= (nextPhase == PH_RDAT) && !txByte[7];
        end else if ((phase == PH_RDAT) && (bitCnt != 4'd0)) begin
          sdaPullLow <= !txByte[3'd7 - bitCnt[2:0]];
        end
      end
    end
  end

endmodule

// File: rtl/smem_dpath.sv
module smem_dpath
  import smem_pkg::*;
#(
  parameter int ADDR_W = 13
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sdaIn,
  input  strobe_t           strb,
  output logic [7:0]        rxByte,
  output logic [7:0]        txByte,
  output logic              wrValid,
  output logic [ADDR_W-1:0] wrAddr,
  output logic [7:0]        wrData,
  output logic              rdEn,
  output logic [ADDR_W-1:0] rdAddr,
  input  logic [7:0]        rdData
);

  localparam int HI_W = ADDR_W - 8;

  logic [6:0]        shiftReg;
  logic [HI_W-1:0]   addrHi;
  logic [ADDR_W-1:0] addrCnt;
  logic              rdLatch;

  assign rxByte = {shiftReg, sdaIn};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shiftReg <= '0;
      addrHi   <= '0;
      addrCnt  <= '0;
      wrValid  <= 1'b0;
      wrAddr   <= '0;
      wrData   <= '0;
      rdEn     <= 1'b0;
      rdAddr   <= '0;
      rdLatch  <= 1'b0;
      txByte   <= 8'hFF;
    end else begin
      wrValid <= 1'b0;
      rdEn    <= 1'b0;
      rdLatch <= rdEn;
      if (rdLatch) txByte <= rdData;
      if (strb.shiftIn) shiftReg <= rxByte[6:0];
      if (strb.loadHi)  addrHi   <= rxByte[HI_W-1:0];
      if (strb.loadLo)  addrCnt  <= {addrHi, rxByte};
      if (strb.pushWr) begin
        wrValid <= 1'b1;
        wrAddr  <= addrCnt;
        wrData  <= rxByte;
        addrCnt <= addrCnt + 1'b1;
      end
      if (strb.fetchRd) begin
        rdEn    <= 1'b1;
        rdAddr  <= addrCnt;
        addrCnt <= addrCnt + 1'b1;
      end
    end
  end

endmodule

// File: rtl/smem_proto_ctrl.sv
module smem_proto_ctrl
  import smem_pkg::*;
#(
  parameter int         ADDR_W   = 13,
  parameter logic [6:0] SEL_CODE = 7'b1010100
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startEv,
  input  logic              stopEv,
  input  logic              sclRise,
  input  logic              sclFall,
  input  logic              sdaIn,
  input  logic              busy,
  output logic              sdaPullLow,
  output logic              wrValid,
  output logic [ADDR_W-1:0] wrAddr,
  output logic [7:0]        wrData,
  output logic              rdEn,
  output logic [ADDR_W-1:0] rdAddr,
  input  logic [7:0]        rdData
);

  strobe_t    strb;
  logic [7:0] rxByte;
  logic [7:0] txByte;

  smem_ctrl #(.SEL_CODE(SEL_CODE)) ctrl_i (
    .clk(clk), .rstN(rstN), .startEv(startEv), .stopEv(stopEv),
    .sclRise(sclRise), .sclFall(sclFall), .sdaIn(sdaIn), .busy(busy),
    .rxByte(rxByte), .txByte(txByte), .strb(strb), .sdaPullLow(sdaPullLow)
  );

  smem_dpath #(.ADDR_W(ADDR_W)) dpath_i (
    .clk(clk), .rstN(rstN), .sdaIn(sdaIn), .strb(strb),
    .rxByte(rxByte), .txByte(txByte),
    .wrValid(wrValid), .wrAddr(wrAddr), .wrData(wrData),
    .rdEn(rdEn), .rdAddr(rdAddr), .rdData(rdData)
  );

endmodule

// File: rtl/smem_proto_ctrl_chk.sv
module smem_proto_ctrl_chk (
  input logic clk,
  input logic rstN,
  input logic startEv,
  input logic stopEv,
  input logic sclRise,
  input logic sclFall,
  input logic sdaPullLow,
  input logic wrValid,
  input logic rdEn
);

  // R11: line drive moves only after an SCL fall or a bus condition
  a_r11_pull_moves_on_fall: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(sdaPullLow) |-> $past(sclFall || startEv || stopEv));

  // R10: START frees the line
  a_r10_start_frees_line: assert property (@(posedge clk) disable iff (!rstN)
    startEv |=> !sdaPullLow);

  // R10: STOP frees the line
  a_r10_stop_frees_line: assert property (@(posedge clk) disable iff (!rstN)
    stopEv |=> !sdaPullLow);

  // R3: a byte push follows the 8th SCL rise of a byte
  a_r3_push_after_rise: assert property (@(posedge clk) disable iff (!rstN)
    wrValid |-> $past(sclRise));

  // R3: push and fetch never coincide
  a_r3_push_not_with_fetch: assert property (@(posedge clk) disable iff (!rstN)
    !(wrValid && rdEn));

  // R7: a fetch follows an SCL rise (select or host ACK)
  a_r7_fetch_after_rise: assert property (@(posedge clk) disable iff (!rstN)
    rdEn |-> $past(sclRise));

endmodule

bind smem_proto_ctrl smem_proto_ctrl_chk chk_i (
  .clk(clk), .rstN(rstN), .startEv(startEv), .stopEv(stopEv),
  .sclRise(sclRise), .sclFall(sclFall), .sdaPullLow(sdaPullLow),
  .wrValid(wrValid), .rdEn(rdEn)
);

// File: tb/smem_proto_ctrl_tb_top.sv
module smem_proto_ctrl_tb_top;

  localparam int AW = 13;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          startEv = 1'b0, stopEv = 1'b0, sclRise = 1'b0, sclFall = 1'b0;
  logic          sdaIn = 1'b1, busy = 1'b0;
  logic          sdaPullLow, wrValid, rdEn;
  logic [AW-1:0] wrAddr, rdAddr;
  logic [7:0]    wrData;
  logic [7:0]    rdData = 8'h00;

  int checks = 0;
  int errors = 0;
  logic [3:0]    wrCnt = '0;
  logic [AW-1:0] wrLogA [8];
  logic [7:0]    wrLogD [8];

  always #5 clk = ~clk;

  smem_proto_ctrl dut_i (
    .clk(clk), .rstN(rstN), .startEv(startEv), .stopEv(stopEv),
    .sclRise(sclRise), .sclFall(sclFall), .sdaIn(sdaIn), .busy(busy),
    .sdaPullLow(sdaPullLow), .wrValid(wrValid), .wrAddr(wrAddr),
    .wrData(wrData), .rdEn(rdEn), .rdAddr(rdAddr), .rdData(rdData)
  );

  // memory model: computed content
  function automatic logic [7:0] pat(input logic [AW-1:0] a);
    return a[7:0] ^ {a[12:8], 3'b101};
  endfunction

  always @(posedge clk) begin
    if (rdEn) rdData <= pat(rdAddr);
    if (wrValid) begin
      wrLogA[wrCnt[2:0]] <= wrAddr;
      wrLogD[wrCnt[2:0]] <= wrData;
      wrCnt <= wrCnt + 4'd1;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic clkBit(input logic b, output logic pullHi);
    sdaIn = b;
    repeat (2) tick();
    sclRise = 1'b1; tick(); sclRise = 1'b0;
    repeat (3) tick();
    pullHi = sdaPullLow;
    sclFall = 1'b1; tick(); sclFall = 1'b0;
    repeat (3) tick();
  endtask

  task automatic sendByte(input logic [7:0] v, output logic acked);
    logic p;
    for (int i = 7; i >= 0; i--) clkBit(v[i], p);
    clkBit(1'b1, p);
    acked = p;
  endtask

  task automatic recvByte(input logic hostAck, output logic [7:0] v, output logic released);
    logic p;
    for (int i = 7; i >= 0; i--) begin
      clkBit(1'b1, p);
      v[i] = !p;
    end
    clkBit(!hostAck, p);
    released = !p;
  endtask

  task automatic busStart();
    sdaIn = 1'b1; tick();
    startEv = 1'b1; tick(); startEv = 1'b0; repeat (2) tick();
  endtask

  task automatic busStop();
    stopEv = 1'b1; tick(); stopEv = 1'b0; repeat (2) tick();
    sdaIn = 1'b1;
  endtask

  task automatic setAddr(input logic [15:0] a, input string req);
    logic ack;
    busStart();
    sendByte(8'hA8, ack); check({req, " sel ack"}, ack, 1);
    sendByte(a[15:8], ack); check({req, " addr hi ack"}, ack, 1);
    sendByte(a[7:0], ack);  check({req, " addr lo ack"}, ack, 1);
  endtask

  // random-read vectors: {16-bit address, expected byte}
  localparam logic [23:0] RD_VEC [6] = '{
    {16'h0000, 8'h05},
    {16'h0ABC, 8'hE9},
    {16'h1FFF, 8'h02},
    {16'hE005, 8'h00},   // R4: upper bits ignored
    {16'h2100, 8'h0D},   // R4
    {16'h1234, 8'hA1}
  };

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic ack, rel;
    logic [7:0] d;
    logic [3:0] wr0;
    repeat (3) tick();
    rstN = 1'b1;
    tick();
    // R1 reset state
    check("R1 pull", sdaPullLow, 0);
    check("R1 push", wrValid, 0);
    check("R1 fetch", rdEn, 0);

    // R6 / R4 random reads from the table
    foreach (RD_VEC[k]) begin
      setAddr(RD_VEC[k][23:8], "R6");
      busStart();
      sendByte(8'hA9, ack); check("R6 read sel ack", ack, 1);
      recvByte(1'b0, d, rel);
      check("R6 R4 random read data", d, RD_VEC[k][7:0]);
      check("R11 ack slot released", rel, 1);
      busStop();
    end

    // R3 write two bytes
    wr0 = wrCnt;
    setAddr(16'h0123, "R3");
    sendByte(8'h5A, ack); check("R3 data ack 0", ack, 1);
    sendByte(8'hC3, ack); check("R3 data ack 1", ack, 1);
    busStop();
    check("R3 push count", wrCnt - wr0, 2);
    check("R3 addr 0", wrLogA[wr0[2:0]], 13'h0123);
    check("R3 data 0", wrLogD[wr0[2:0]], 8'h5A);
    check("R3 addr 1", wrLogA[wr0[2:0] + 3'd1], 13'h0124);
    check("R3 data 1", wrLogD[wr0[2:0] + 3'd1], 8'hC3);

    // R5 current address reads
    busStart();
    sendByte(8'hA9, ack); check("R5 sel ack", ack, 1);
    recvByte(1'b0, d, rel); check("R5 current read 0x125", d, 8'h28);
    busStop();
    busStart();
    sendByte(8'hA9, ack);
    recvByte(1'b0, d, rel); check("R5 current read 0x126", d, 8'h2B);
    busStop();

    // R7 sequential read across the top of the array
    setAddr(16'h1FFE, "R7");
    busStart();
    sendByte(8'hA9, ack);
    recvByte(1'b1, d, rel); check("R7 seq 0x1FFE", d, 8'h03);
    recvByte(1'b1, d, rel); check("R7 seq 0x1FFF", d, 8'h02);
    recvByte(1'b0, d, rel); check("R7 seq wrap 0x0000", d, 8'h05);
    // R8 after NACK nothing is driven
    recvByte(1'b0, d, rel); check("R8 idle after nack", d, 8'hFF);
    busStop();

    // R2 wrong select code
    wr0 = wrCnt;
    busStart();
    sendByte(8'hA0, ack); check("R2 mismatch no ack", ack, 0);
    sendByte(8'h00, ack); check("R2 ignored byte no ack", ack, 0);
    sendByte(8'h77, ack); check("R2 ignored data no ack", ack, 0);
    busStop();
    check("R2 no push", wrCnt - wr0, 0);

    // R9 busy polling
    busy = 1'b1;
    busStart();
    sendByte(8'hA8, ack); check("R9 busy no ack", ack, 0);
    busStop();
    busy = 1'b0;
    busStart();
    sendByte(8'hA8, ack); check("R9 ready ack", ack, 1);
    busStop();

    // R10 start aborts address phase; counter still 0x0001
    busStart();
    sendByte(8'hA8, ack);
    sendByte(8'h00, ack);
    busStart();
    sendByte(8'hA9, ack); check("R10 restart sel ack", ack, 1);
    recvByte(1'b0, d, rel); check("R10 read after abort", d, 8'h04);
    busStop();

    // R10 stop aborts; later bytes unanswered
    busStart();
    sendByte(8'hA8, ack);
    busStop();
    sendByte(8'h12, ack); check("R10 no ack after stop", ack, 0);
    check("R10 line free", sdaPullLow, 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule